// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block sits between a two-wire serial slave engine and a non-volatile memory array. Once the slave engine has decoded a write control byte and the two address bytes, it loads the start address here. It then streams the data bytes of the transfer into a page-sized latch, which by default holds 128 bytes. The same path serves a single-byte write and a page write. Each accepted byte goes to the next offset of the latch, and the offset wraps within the page. A record of which offsets were touched in the current transfer is kept beside the latch.

When the bus Stop arrives after at least one data byte and the write-protect input is low, the block starts a self-timed programming cycle. The cycle has two parts. First it scans the latch in ascending offset order and pushes every touched entry to the array over a valid/ready write port. Then it waits for a fixed, parameterized number of clocks that stands in for the physical programming time. For the whole cycle it raises `busy`, which the slave engine uses to stop acknowledging control bytes.

Back-pressure works as follows. The data-byte input is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while a write transfer is open. The array port presents an entry with `arr_valid` and holds address and data steady until `arr_ready` is seen high.

Top module: `eeprom_page_wbuf`

## Requirements
- R1: During and right after reset, `busy`, `arr_valid` and `in_ready` are all low.
- R2: An `addr_load` pulse while not busy opens a write transfer. From the next cycle on, `in_ready` is high. The page base is taken from `addr_in[16:7]` and the starting offset from `addr_in[6:0]`.
- R3: Each accepted byte is stored at the current offset, and the offset then increments modulo 128. A later byte that lands on an offset already written in the same transfer replaces the earlier value.
- R4: In the programming cycle, array writes are issued only for offsets written in this transfer, in ascending offset order 0 to 127. Each write has address {page base, offset}. While `arr_valid` is high and `arr_ready` is low, `arr_valid`, `arr_addr` and `arr_data` hold their values.
- R5: `busy` rises in the cycle after the Stop and stays high through the whole scan and wait. While it is high, `in_ready` is low and `addr_load`, `in_valid` and `bus_stop` have no effect.
- R6: A Stop that follows only the address, with no data byte, starts no programming cycle, and neither does a `bus_rstart` during the transfer. In both cases `busy` stays low and the array receives no writes.
- R7: With `wp` high at the Stop, data bytes are still accepted (`in_ready` high), but no array write and no busy period follow.
- R8: After the scan of the last offset completes, `busy` stays high for exactly `PROG_CYCLES` further cycles. With `arr_ready` held high, a cycle lasts 128 + `PROG_CYCLES` cycles.
- R9: The record of written offsets starts empty in each new transfer, so offsets written in an earlier transfer are not written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp | input | 1 | Write protect; high inhibits the programming cycle |
| addr_load | input | 1 | Pulse: start address of a write transfer is valid |
| addr_in | input | ADDR_W | Start byte address (block bit and 16-bit word address) |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Data byte can be taken (write transfer open) |
| in_data | input | 8 | Data byte |
| bus_stop | input | 1 | Pulse: Stop condition seen on the bus |
| bus_rstart | input | 1 | Pulse: repeated Start seen on the bus |
| arr_valid | output | 1 | Array write request |
| arr_ready | input | 1 | Array takes the request |
| arr_addr | output | ADDR_W | Array byte address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |

## Verification
The assertions check on every cycle that the array port holds a stalled request steady, that array requests and busy never overlap an open transfer, that the page base does not move during a cycle, and that a protected Stop or a repeated Start never makes `busy` rise. Only the bench scenarios can show the rest: which offsets reach the array and with which values after page wrap and overwrite, the exact length of the busy period, and that a fresh transfer forgets the previous one's offsets. A behavioural model in the bench follows every cycle of these scenarios under both free-running and stalling `arr_ready`.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
  typedef enum logic [1:0] {
    EWB_IDLE = 2'd0,
    EWB_FILL = 2'd1,
    EWB_SCAN = 2'd2,
    EWB_HOLD = 2'd3
  } ewb_state_t;
endpackage

// File: rtl/ewb_page_latch.sv
module ewb_page_latch #(
  parameter int ENTRIES = 128,
  parameter int DATA_W  = 8,
  localparam int OFF_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mask
);
  logic [DATA_W-1:0] ent [ENTRIES];
  logic [ENTRIES-1:0] touched;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              hit;
    logic              t_q;
    logic [DATA_W-1:0] d_q;
    assign hit = wr_en && (wr_off == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (hit) begin
          t_q <= 1'b1;
          d_q <= wr_data;
        end else if (clr) begin
          t_q <= 1'b0;
        end
      end
    end
    assign touched[g] = t_q;
    assign ent[g]     = d_q;
  end

  assign rd_data = ent[rd_off];
  assign rd_mask = touched[rd_off];
endmodule

// File: rtl/ewb_commit_scan.sv
module ewb_commit_scan #(
  parameter int ENTRIES = 128,
  localparam int OFF_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ent_used,
  input  logic             arr_ready,
  output logic             active,
  output logic [OFF_W-1:0] idx,
  output logic             done
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(ENTRIES - 1);
  logic step;

  assign step = active && (!ent_used || arr_ready);
  assign done = step && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (step) begin
      if (idx == LAST) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/ewb_prog_timer.sv
module ewb_prog_timer #(
  parameter int CYCLES = 300,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);
  logic [CNT_W-1:0] cnt;

  assign done = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) active <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_page_wbuf.sv
module eeprom_page_wbuf #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 300,
  localparam int DATA_W     = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int BASE_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bus_stop,
  input  logic              bus_rstart,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy
);
  import ewb_pkg::*;

  ewb_state_t        st;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              have_q;
  logic              beat, go, reload;
  logic              scan_active, scan_done, tmr_active, tmr_done;
  logic [OFF_W-1:0]  scan_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_mask;

  assign in_ready = (st == EWB_FILL);
  assign beat     = in_valid && in_ready;
  assign go       = (st == EWB_FILL) && bus_stop && (have_q || beat) && !wp;
  assign reload   = addr_load &&
                    ((st == EWB_IDLE) || ((st == EWB_FILL) && !bus_stop && !bus_rstart));
  assign busy     = (st == EWB_SCAN) || (st == EWB_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EWB_IDLE;
      base_q <= '0;
      ptr_q  <= '0;
      have_q <= 1'b0;
    end else begin
      unique case (st)
        EWB_IDLE: if (reload) st <= EWB_FILL;
        EWB_FILL: begin
          if (bus_stop)        st <= go ? EWB_SCAN : EWB_IDLE;
          else if (bus_rstart) st <= EWB_IDLE;
          else if (beat) begin
            ptr_q  <= ptr_q + 1'b1;
            have_q <= 1'b1;
          end
        end
        EWB_SCAN: if (scan_done) st <= EWB_HOLD;
        EWB_HOLD: if (tmr_done)  st <= EWB_IDLE;
        default:  st <= EWB_IDLE;
      endcase
      if (reload) begin
        base_q <= addr_in[ADDR_W-1:OFF_W];
        ptr_q  <= addr_in[OFF_W-1:0];
        have_q <= 1'b0;
      end
    end
  end

  ewb_page_latch #(.ENTRIES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (reload),
    .wr_en   (beat),
    .wr_off  (ptr_q),
    .wr_data (in_data),
    .rd_off  (scan_idx),
    .rd_data (rd_data),
    .rd_mask (rd_mask)
  );

  ewb_commit_scan #(.ENTRIES(PAGE_BYTES)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .ent_used  (rd_mask),
    .arr_ready (arr_ready),
    .active    (scan_active),
    .idx       (scan_idx),
    .done      (scan_done)
  );

  ewb_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (scan_done),
    .active (tmr_active),
    .done   (tmr_done)
  );

  assign arr_valid = scan_active && rd_mask;
  assign arr_addr  = {base_q, scan_idx};
  assign arr_data  = rd_data;
endmodule

// File: rtl/ewb_page_wbuf_sva.sv
module ewb_page_wbuf_sva #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic              bus_stop,
  input logic              bus_rstart,
  input logic              in_ready,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [7:0]        arr_data,
  input logic              busy
);
  // R4: a stalled array request keeps its payload
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && !arr_ready |=> arr_valid && $stable(arr_addr) && $stable(arr_data));

  // R4: array requests appear only inside a programming cycle
  p_req_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> busy);

  // R4: page base fixed for the whole cycle
  p_base_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(arr_addr[ADDR_W-1:OFF_W]));

  // R5: no byte acceptance while busy
  p_no_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R6: a repeated start never launches a cycle
  p_rstart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rstart && !bus_stop && !busy |=> !busy);

  // R7: a protected Stop never launches a cycle
  p_wp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop && wp && !busy |=> !busy);
endmodule

bind eeprom_page_wbuf ewb_page_wbuf_sva #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp         (wp),
  .bus_stop   (bus_stop),
  .bus_rstart (bus_rstart),
  .in_ready   (in_ready),
  .arr_valid  (arr_valid),
  .arr_ready  (arr_ready),
  .arr_addr   (arr_addr),
  .arr_data   (arr_data),
  .busy       (busy)
);

// File: tb/tb_eeprom_page_wbuf.sv
`timescale 1ns/1ps
module tb_eeprom_page_wbuf;
  localparam int AW = 17;
  localparam int PC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, addr_load = 1'b0, in_valid = 1'b0, bus_stop = 1'b0, bus_rstart = 1'b0;
  logic arr_ready = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] in_data = '0;
  logic in_ready, arr_valid, busy;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_data;

  int checks = 0, errors = 0;
  int rdy_mode = 0, cyc = 0;
  bit fin = 1'b0;

  // behavioural model
  int ph = 0, m_ptr = 0, m_base = 0, m_idx = 0, m_cnt = 0;
  bit m_have = 1'b0;
  int m_lat [128];
  bit m_msk [128];
  logic [7:0] dut_arr [int];
  int wcnt = 0;
  int first_addr = -1;

  always #5 clk = ~clk;

  eeprom_page_wbuf #(.ADDR_W(AW), .PAGE_BYTES(128), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .addr_load(addr_load), .addr_in(addr_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bus_stop(bus_stop), .bus_rstart(bus_rstart),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data), .busy(busy));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // model update and array capture
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_have = 0;
    end else begin
      if (arr_valid && arr_ready) begin
        dut_arr[int'(arr_addr)] = arr_data;
        if (wcnt == 0) first_addr = int'(arr_addr);
        wcnt++;
      end
      case (ph)
        0, 1: begin
          bit beat;
          beat = (ph == 1) && in_valid;
          if (beat) begin
            m_lat[m_ptr] = int'(in_data); m_msk[m_ptr] = 1'b1;
          end
          if (ph == 1 && bus_stop) begin
            if ((m_have || beat) && !wp) begin ph = 2; m_idx = 0; end
            else ph = 0;
          end else if (ph == 1 && bus_rstart) ph = 0;
          else if (addr_load) begin
            ph = 1; m_base = int'(addr_in) / 128; m_ptr = int'(addr_in) % 128; m_have = 0;
            foreach (m_msk[i]) m_msk[i] = 1'b0;
          end else if (beat) begin
            m_ptr = (m_ptr + 1) % 128; m_have = 1;
          end
        end
        2: if (!m_msk[m_idx] || arr_ready) begin
             if (m_idx == 127) begin ph = 3; m_cnt = 0; end
             else m_idx++;
           end
        default: if (m_cnt == PC - 1) ph = 0; else m_cnt++;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit e_av;
      e_av = (ph == 2) && m_msk[m_idx];
      chk(busy == (ph >= 2), "R5/R8", "busy", busy, ph >= 2);
      chk(in_ready == (ph == 1), "R2/R5", "in_ready", in_ready, ph == 1);
      chk(arr_valid == e_av, "R4", "arr_valid", arr_valid, e_av);
      if (e_av) begin
        chk(int'(arr_addr) == m_base * 128 + m_idx, "R4", "arr_addr", arr_addr, m_base * 128 + m_idx);
        chk(int'(arr_data) == m_lat[m_idx], "R3", "arr_data", arr_data, m_lat[m_idx]);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      arr_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end
  end

  task automatic pulse_addr(input int a);
    @(posedge clk); #1 addr_load = 1; addr_in = AW'(a);
    @(posedge clk); #1 addr_load = 0;
  endtask
  task automatic send_byte(input int d);
    @(posedge clk); #1 in_valid = 1; in_data = 8'(d);
    @(posedge clk); #1 in_valid = 0;
  endtask
  task automatic pulse_stop();
    @(posedge clk); #1 bus_stop = 1;
    @(posedge clk); #1 bus_stop = 0;
  endtask
  task automatic pulse_rstart();
    @(posedge clk); #1 bus_rstart = 1;
    @(posedge clk); #1 bus_rstart = 0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(arr_valid == 0, "R1", "reset arr_valid", arr_valid, 0);
    chk(in_ready == 0, "R1", "reset in_ready", in_ready, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready == 0 && busy == 0, "R1", "after reset idle", {in_ready, busy}, 0);

    // single byte write, block bit set
    pulse_addr('h12345);
    @(negedge clk);
    chk(in_ready == 1, "R2", "in_ready after addr_load", in_ready, 1);
    wcnt = 0;
    send_byte('hA5);
    pulse_stop();
    wait_idle(n);
    chk(n == 128 + PC, "R8", "busy length", n, 128 + PC);
    chk(wcnt == 1, "R4", "single write count", wcnt, 1);
    chk(dut_arr.exists('h12345) && dut_arr['h12345] == 8'hA5, "R2", "byte at 12345", wcnt, 'hA5);

    // page write wrapping, stalling array
    rdy_mode = 1; wcnt = 0; first_addr = -1;
    pulse_addr('h0807E);
    send_byte('h11); send_byte('h22); send_byte('h33); send_byte('h44);
    pulse_stop();
    wait_idle(n);
    chk(wcnt == 4, "R4", "wrap write count", wcnt, 4);
    chk(first_addr == 'h08000, "R4", "ascending order first addr", first_addr, 'h08000);
    chk(dut_arr['h0807E] == 8'h11 && dut_arr['h0807F] == 8'h22, "R3", "tail of page", dut_arr['h0807F], 'h22);
    chk(dut_arr['h08000] == 8'h33 && dut_arr['h08001] == 8'h44, "R3", "wrap to page start", dut_arr['h08001], 'h44);

    // 130 bytes: overwrite after wrap
    wcnt = 0;
    pulse_addr('h00010);
    for (int i = 0; i < 130; i++) send_byte(i);
    pulse_stop();
    wait_idle(n);
    chk(wcnt == 128, "R3", "full page count", wcnt, 128);
    chk(dut_arr['h00010] == 8'd128, "R3", "overwrite at 10", dut_arr['h00010], 128);
    chk(dut_arr['h00011] == 8'd129, "R3", "overwrite at 11", dut_arr['h00011], 129);
    chk(dut_arr['h0000F] == 8'd127, "R3", "last before wrap", dut_arr['h0000F], 127);

    // write protect
    rdy_mode = 0; wcnt = 0; wp = 1;
    pulse_addr('h00200);
    @(negedge clk);
    chk(in_ready == 1, "R7", "bytes accepted under wp", in_ready, 1);
    send_byte('h5A); send_byte('h5B);
    pulse_stop();
    repeat (5) @(negedge clk);
    chk(busy == 0, "R7", "no busy under wp", busy, 0);
    chk(wcnt == 0 && !dut_arr.exists('h00200), "R7", "no write under wp", wcnt, 0);
    wp = 0;

    // Stop after address only, and repeated start abort
    pulse_addr('h00400);
    pulse_stop();
    repeat (3) @(negedge clk);
    chk(busy == 0 && wcnt == 0, "R6", "address-only stop", busy, 0);
    pulse_addr('h00480);
    send_byte('h99);
    pulse_rstart();
    repeat (3) @(negedge clk);
    chk(busy == 0 && in_ready == 0, "R6", "rstart abort", {busy, in_ready}, 0);
    pulse_stop();
    repeat (3) @(negedge clk);
    chk(wcnt == 0 && !dut_arr.exists('h00480), "R6", "no write after abort", wcnt, 0);

    // inputs ignored while busy; fresh mask per transfer
    pulse_addr('h00300);
    send_byte('hC0); send_byte('hC1);
    pulse_stop();
    pulse_addr('h00350);
    send_byte('hEE);
    pulse_stop();
    wait_idle(n);
    repeat (2) @(negedge clk);
    chk(in_ready == 0 && busy == 0, "R5", "addr_load ignored while busy", {in_ready, busy}, 0);
    chk(!dut_arr.exists('h00350), "R5", "byte ignored while busy", dut_arr.exists('h00350), 0);
    wcnt = 0;
    pulse_addr('h00301);
    send_byte('h77);
    pulse_stop();
    wait_idle(n);
    chk(wcnt == 1, "R9", "only new offset written", wcnt, 1);
    chk(dut_arr['h00300] == 8'hC0 && dut_arr['h00301] == 8'h77, "R9", "earlier offset kept", dut_arr['h00300], 'hC0);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule